// File: doc/BRIEF.md
# Edge-Event Level Link with Failsafe Output

This block carries a single logic level from a sending side to a receiving side by using discrete events instead of a continuous wire. The sending half samples `dataIn`, can optionally reject short glitches, and turns each level change into a one-cycle pulse. A rising level produces a pulse on `txSet` and a falling level produces a pulse on `txClr`. While the level does not change, the sending half emits the same kind of pulse at a fixed interval, so the receiving side keeps learning the current level.

The receiving half holds `dataOut` in a set/clear latch driven by `rxSet` and `rxClr`. A watchdog watches for incoming events. When none arrives for a whole timeout window, the receiving half concludes that the source is unpowered or undriven and forces `dataOut` high. It reports this condition on `failsafeActive`. The two event wires leave the block and come back in, so the channel between the halves can be modelled outside the block: a straight loopback, a cut line, or corrupted events.

The timeout window is a count of time units times cycles per unit. The default is 4 units of 10 cycles. The refresh interval must be shorter than this window, and an elaboration check rejects any parameter set in which it is not.

Top module: `edge_link`

## Requirements
- R1: While `rstN` is low, `dataOut` and `failsafeActive` are 1 and both `txSet` and `txClr` are 0.
- R2: A filtered rising level change produces exactly one cycle of `txSet`, and a filtered falling change produces exactly one cycle of `txClr`. The two are never high together. With the filter enabled, the pulse appears FILTER_LEN (default 3) cycles later than it would without the filter.
- R3: An `rxSet` pulse without `rxClr` drives `dataOut` to 1 on the next cycle. An `rxClr` pulse without `rxSet` drives it to 0. Either pulse clears `failsafeActive`.
- R4: When `rxSet` and `rxClr` are high in the same cycle, that event is ignored. `dataOut` holds its value, the watchdog is not restarted, and an active failsafe stays active.
- R5: With a static input, the sending half emits one pulse every REFRESH_CYCLES (default 16) cycles, counted from the previous pulse. The pulse is `txSet` for level 1 and `txClr` for level 0. `dataOut` keeps that level with no failsafe for as long as the input stays static.
- R6: When TIMEOUT_CYCLES (default 40) clock cycles pass without a valid event, `failsafeActive` goes to 1 and `dataOut` to 1. The next valid event leaves the failsafe state and sets `dataOut` to the event's level.
- R7: With the filter enabled, an input excursion lasting fewer than FILTER_LEN cycles produces no event and leaves `dataOut` unchanged. An excursion lasting FILTER_LEN cycles produces an event.
- R8: With the filter disabled, a change on `dataIn` shows as a pulse on the very next cycle. `dataOut` follows one cycle after that.
- R9: Over a direct loopback with the filter enabled, `dataOut` takes the new input level FILTER_LEN+2 cycles after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 1 | Logic level to be carried |
| txSet | output | 1 | Sending-half event: level is 1 |
| txClr | output | 1 | Sending-half event: level is 0 |
| rxSet | input | 1 | Receiving-half event: set the latch |
| rxClr | input | 1 | Receiving-half event: clear the latch |
| dataOut | output | 1 | Received level, forced to 1 in failsafe |
| failsafeActive | output | 1 | High while no event has arrived within the timeout |

## Verification
A wrong refresh counter shows up at the ports as an event gap other than REFRESH_CYCLES. In the worst case the spacing is so long that the failsafe trips on a static input, which becomes visible within one timeout window. A wrong watchdog count moves the rise of `failsafeActive` away from the exact cycle after a clean channel cut. Conflicting events give the watchdog no restart, so a slip there shows as an exact-cycle error. A filter whose counter is off by one either lets a FILTER_LEN-1 glitch through as an event or shifts the edge latency by a cycle. Both can be seen within a few cycles of the input change.

// File: rtl/edge_link_pkg.sv
package edge_link_pkg;

  // Strobes from the sending control to the event datapath.
  typedef struct packed {
    logic sendSet;
    logic sendClr;
  } linkStrobe_t;

endpackage

// File: rtl/edge_link_ctrl.sv
module edge_link_ctrl
  import edge_link_pkg::*;
#(
  parameter bit FILTER_EN      = 1'b1,
  parameter int FILTER_LEN     = 3,
  parameter int REFRESH_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        dataIn,
  output linkStrobe_t strobe
);

  localparam int RW = (REFRESH_CYCLES > 1) ? $clog2(REFRESH_CYCLES) : 1;
  localparam int FW = (FILTER_LEN > 1) ? $clog2(FILTER_LEN) : 1;

  logic          level;
  logic          prevLevel;
  logic [RW-1:0] refCnt;
  logic          edgeSeen;
  logic          refreshDue;
  logic          anyEvt;

  generate
    if (FILTER_EN) begin : g_filter
      logic          heldLevel;
      logic [FW-1:0] runCnt;

      // A new level is accepted once it has been sampled FILTER_LEN times in a row.
      always_ff @(posedge clk) begin
        if (!rstN) begin
          heldLevel <= 1'b1;
          runCnt    <= '0;
        end else if (dataIn == heldLevel) begin
          runCnt <= '0;
        end else if (runCnt == FW'(FILTER_LEN - 1)) begin
          heldLevel <= dataIn;
          runCnt    <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end

      assign level = heldLevel;
    end else begin : g_bypass
      assign level = dataIn;
    end
  endgenerate

  assign edgeSeen   = (level != prevLevel);
  assign refreshDue = (refCnt == RW'(REFRESH_CYCLES - 1));
  assign anyEvt     = edgeSeen | refreshDue;

  // An edge event and a refresh both restate the current level.
  assign strobe.sendSet = anyEvt & level;
  assign strobe.sendClr = anyEvt & ~level;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLevel <= 1'b1;
      refCnt    <= '0;
    end else begin
      prevLevel <= level;
      refCnt    <= anyEvt ? '0 : refCnt + 1'b1;
    end
  end

endmodule

// File: rtl/edge_link_dp.sv
module edge_link_dp
  import edge_link_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  linkStrobe_t strobe,
  input  logic        rxSet,
  input  logic        rxClr,
  output logic        txSet,
  output logic        txClr,
  output logic        dataOut,
  output logic        failsafeActive
);

  localparam int WW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;

  logic          latchLevel;
  logic          failsafe;
  logic [WW-1:0] wdCnt;
  logic          validEvt;

  // Registered event outputs.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSet <= 1'b0;
      txClr <= 1'b0;
    end else begin
      txSet <= strobe.sendSet;
      txClr <= strobe.sendClr;
    end
  end

  // Only an unambiguous event counts; a set/clear pair is dropped.
  assign validEvt = rxSet ^ rxClr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchLevel <= 1'b1;
      failsafe   <= 1'b1;
      wdCnt      <= '0;
    end else if (validEvt) begin
      latchLevel <= rxSet;
      failsafe   <= 1'b0;
      wdCnt      <= '0;
    end else if (!failsafe) begin
      if (wdCnt == WW'(TIMEOUT_CYCLES - 1)) begin
        failsafe <= 1'b1;
      end else begin
        wdCnt <= wdCnt + 1'b1;
      end
    end
  end

  assign dataOut        = failsafe | latchLevel;
  assign failsafeActive = failsafe;

endmodule

// File: rtl/edge_link.sv
module edge_link
  import edge_link_pkg::*;
#(
  parameter bit FILTER_EN      = 1'b1,
  parameter int FILTER_LEN     = 3,
  parameter int REFRESH_CYCLES = 16,
  parameter int TIMEOUT_UNITS  = 4,
  parameter int UNIT_CYCLES    = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic dataIn,
  output logic txSet,
  output logic txClr,
  input  logic rxSet,
  input  logic rxClr,
  output logic dataOut,
  output logic failsafeActive
);

  localparam int TIMEOUT_CYCLES = TIMEOUT_UNITS * UNIT_CYCLES;

  generate
    if (REFRESH_CYCLES >= TIMEOUT_CYCLES || REFRESH_CYCLES < 2) begin : g_bad_refresh
      $error("edge_link: REFRESH_CYCLES must be at least 2 and below the timeout window");
    end
  endgenerate

  linkStrobe_t strobe;

  edge_link_ctrl #(
    .FILTER_EN     (FILTER_EN),
    .FILTER_LEN    (FILTER_LEN),
    .REFRESH_CYCLES(REFRESH_CYCLES)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .dataIn(dataIn),
    .strobe(strobe)
  );

  edge_link_dp #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .rxSet         (rxSet),
    .rxClr         (rxClr),
    .txSet         (txSet),
    .txClr         (txClr),
    .dataOut       (dataOut),
    .failsafeActive(failsafeActive)
  );

endmodule

// File: rtl/edge_link_chk.sv
module edge_link_chk #(
  parameter int TIMEOUT_CYCLES = 40
) (
  input logic clk,
  input logic rstN,
  input logic txSet,
  input logic txClr,
  input logic rxSet,
  input logic rxClr,
  input logic dataOut,
  input logic failsafeActive
);

  localparam int QW = $clog2(TIMEOUT_CYCLES + 1);

  // Cycles since the last unambiguous received event, saturating.
  logic [QW-1:0] quietCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quietCnt <= '0;
    end else if (rxSet ^ rxClr) begin
      quietCnt <= '0;
    end else if (quietCnt != QW'(TIMEOUT_CYCLES)) begin
      quietCnt <= quietCnt + 1'b1;
    end
  end

  // R2
  tx_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txSet, txClr}));

  // R2
  tx_set_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    txSet |=> !txSet);

  // R3
  rx_set_applies_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxSet && !rxClr) |=> (dataOut && !failsafeActive));

  // R3
  rx_clr_applies_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxClr && !rxSet) |=> (!dataOut && !failsafeActive));

  // R4
  conflict_keeps_failsafe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxSet && rxClr && failsafeActive) |=> failsafeActive);

  // R4
  conflict_holds_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxSet && rxClr && !dataOut) |=> (!dataOut || failsafeActive));

  // R6
  failsafe_forces_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    failsafeActive |-> dataOut);

  // R6
  timeout_trips_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quietCnt == QW'(TIMEOUT_CYCLES)) |-> failsafeActive);

  // R6
  no_early_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failsafeActive) |-> (quietCnt == QW'(TIMEOUT_CYCLES)));

endmodule

bind edge_link edge_link_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (.*);

// File: tb/test_edge_link.sv
`timescale 1ns/1ps
module test_edge_link;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataIn = 1'b1;
  logic cut = 1'b0;
  logic inj = 1'b0;
  logic injSet = 1'b0;
  logic injClr = 1'b0;

  logic txSet, txClr, rxSet, rxClr, dataOut, failsafeActive;
  logic rTxSet, rTxClr, rOut, rFs;

  int checks = 0;
  int errors = 0;

  localparam int FLEN    = 3;
  localparam int REFRESH = 16;
  localparam int TIMEOUT = 40;

  always #10 clk = ~clk;

  assign rxSet = inj ? injSet : (cut ? 1'b0 : txSet);
  assign rxClr = inj ? injClr : (cut ? 1'b0 : txClr);

  edge_link i_edge_link (
    .clk(clk), .rstN(rstN), .dataIn(dataIn),
    .txSet(txSet), .txClr(txClr), .rxSet(rxSet), .rxClr(rxClr),
    .dataOut(dataOut), .failsafeActive(failsafeActive)
  );

  edge_link #(.FILTER_EN(1'b0)) i_edge_link_raw (
    .clk(clk), .rstN(rstN), .dataIn(dataIn),
    .txSet(rTxSet), .txClr(rTxClr), .rxSet(rTxSet), .rxClr(rTxClr),
    .dataOut(rOut), .failsafeActive(rFs)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitClr(input int limit);
    for (int i = 0; i < limit && !txClr; i++) step(1);
  endtask

  task automatic t_reset();
    step(2);
    chk("R1", "dataOut in reset", dataOut, 1);
    chk("R1", "failsafe in reset", failsafeActive, 1);
    chk("R1", "tx events in reset", {txSet, txClr}, 0);
    rstN = 1'b1;
    step(20);
    chk("R5", "failsafe cleared by refresh", failsafeActive, 0);
    chk("R5", "static high level", dataOut, 1);
  endtask

  task automatic t_edges();
    dataIn = 1'b0;
    step(1);
    chk("R8", "unfiltered clr pulse", rTxClr, 1);
    step(1);
    chk("R8", "unfiltered output low", rOut, 0);
    step(2);
    chk("R2", "filtered clr pulse timing", txClr, 1);
    chk("R9", "output not yet low", dataOut, 1);
    step(1);
    chk("R9", "output low after latency", dataOut, 0);
    chk("R2", "clr pulse single cycle", txClr, 0);
    step(10);
    dataIn = 1'b1;
    step(FLEN + 1);
    chk("R2", "filtered set pulse timing", txSet, 1);
    chk("R9", "output not yet high", dataOut, 0);
    step(1);
    chk("R9", "output high after latency", dataOut, 1);
  endtask

  task automatic t_glitch();
    int sawClr = 0;
    int sawLow = 0;
    step(5);
    dataIn = 1'b0;
    step(FLEN - 1);
    dataIn = 1'b1;
    for (int i = 0; i < 12; i++) begin
      step(1);
      if (txClr) sawClr = 1;
      if (!dataOut) sawLow = 1;
    end
    chk("R7", "short glitch gives no event", sawClr, 0);
    chk("R7", "short glitch leaves output", sawLow, 0);
    dataIn = 1'b0;
    step(FLEN);
    dataIn = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (txClr) sawClr = 1;
      if (!dataOut) sawLow = 1;
    end
    chk("R7", "full-length pulse gives event", sawClr, 1);
    chk("R7", "full-length pulse reaches output", sawLow, 1);
  endtask

  task automatic t_static();
    int gap = 0;
    int nSet = 0;
    int nClr = 0;
    int bad = 0;
    dataIn = 1'b0;
    step(10);
    waitClr(40);
    do begin
      step(1);
      gap++;
    end while (!txClr && gap < 100);
    chk("R5", "refresh spacing", gap, REFRESH);
    for (int i = 0; i < 200; i++) begin
      step(1);
      if (txSet) nSet++;
      if (txClr) nClr++;
      if (dataOut || failsafeActive) bad++;
    end
    chk("R5", "no set refresh at level 0", nSet, 0);
    chk("R5", "clr refresh count", nClr, 200 / REFRESH);
    chk("R5", "static low held without failsafe", bad, 0);
  endtask

  task automatic t_failsafe();
    waitClr(40);
    step(1);
    cut = 1'b1;
    step(TIMEOUT - 1);
    chk("R6", "no failsafe before window", failsafeActive, 0);
    chk("R6", "output low before window", dataOut, 0);
    step(1);
    chk("R6", "failsafe after window", failsafeActive, 1);
    chk("R6", "output forced high", dataOut, 1);
    cut = 1'b0;
    waitClr(40);
    step(1);
    chk("R6", "failsafe left on event", failsafeActive, 0);
    chk("R6", "output restored", dataOut, 0);
  endtask

  task automatic t_conflict();
    inj = 1'b1;
    injClr = 1'b1;
    step(1);
    injSet = 1'b1;
    step(1);
    chk("R4", "conflict holds output", dataOut, 0);
    injSet = 1'b0;
    injClr = 1'b0;
    step(18);
    injSet = 1'b1;
    injClr = 1'b1;
    step(1);
    injSet = 1'b0;
    injClr = 1'b0;
    step(19);
    chk("R4", "conflict no restart, not yet tripped", failsafeActive, 0);
    step(1);
    chk("R4", "conflict did not restart watchdog", failsafeActive, 1);
    injSet = 1'b1;
    injClr = 1'b1;
    step(1);
    chk("R4", "conflict keeps failsafe", failsafeActive, 1);
    injClr = 1'b0;
    step(1);
    chk("R3", "set event clears failsafe", failsafeActive, 0);
    chk("R3", "set event drives high", dataOut, 1);
    injSet = 1'b0;
    injClr = 1'b1;
    step(1);
    chk("R3", "clear event drives low", dataOut, 0);
    injClr = 1'b0;
    inj = 1'b0;
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_edges();
    t_glitch();
    t_static();
    t_failsafe();
    t_conflict();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule